// File: doc/BRIEF.md
# Descriptor Pointer Queue Manager

This block keeps many first-in first-out queues of descriptor pointers. All queues share one link memory indexed by descriptor number, so storage grows with the number of descriptors and not with queues times depth. A producer, either software or a DMA engine, pushes a descriptor by writing its address to the push/pop register of a queue. A consumer pops the head of a queue by reading the same register. The read has no wait states: data comes back in the same cycle and the queue advances at the clock edge.

A region base register and a region control register define how a descriptor address maps to a link index. The control register sets the descriptor size, the number of descriptors and the first link index. The occupancy of every queue is mirrored into packed 32-bit pending words. A one-cycle flag reports any change in those words. A push whose address falls outside the region is dropped and reported on an error output.

Top module: `qm_top`

## Requirements
- R1: The push/pop register of queue n is at byte address 0x200C + 16*n. Writing it appends at the tail. Reading it returns the head and removes it in the same access. Entries leave a queue in the order they were written. Queues do not affect one another.
- R2: A written value carries the descriptor address in bits [31:5] and a size hint in bits [4:0]. A pop returns the same address with its hint restored in bits [4:0].
- R3: Reading the push/pop register of an empty queue returns 0 and changes no state.
- R4: Pending word x is read at 0x90 + 4*x. Bit n%32 of word n/32 is 1 exactly while queue n holds entries. It sets on the push into an empty queue and clears on the pop of the last entry. Bits for queue numbers at or above NUM_QUEUES read 0. Writes to pending words are ignored.
- R5: The region base is a 32-bit register at 0x1000. The region control register is at 0x1004. It holds the first link index in bits [31:16], a size code log2(bytes)-5 in bits [15:8] and a count code log2(descriptors)-5 in bits [4:0]. Both registers read back what was written, with unused control bits reading 0. The link index is (address - base) / size + first index.
- R6: A push is dropped, and addrErr is high in the cycle after that write, in any of these cases: the address is below the base; it is not a multiple of the descriptor size from the base; its descriptor number is at or beyond the region count; or its link index is at or beyond LINK_DEPTH.
- R7: A push and a pop of the same queue in one cycle return the old head and leave the entry count unchanged. The pushed entry lands at the tail. If the queue was empty, the pop returns 0 and the push still lands.
- R8: pendChg is high for the one cycle after a clock edge that changed any pending bit. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write byte address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Register read strobe (a pop when it hits a queue) |
| rdAddr | input | ADDR_W | Read byte address |
| rdData | output | 32 | Read data, valid in the cycle of rdEn |
| addrErr | output | 1 | Rejected push in the previous cycle |
| pendChg | output | 1 | A pending bit changed at the last edge |

## Verification
The bench builds the block with 40 queues and a 64-entry link memory. With 40 queues the second pending word is only partly populated, so the bits that must read 0 are reached. With 64 link entries the region can start at link index 32 and end exactly at the last entry, and moving the first index to 48 pushes a descriptor number past the link memory. A 64-byte size code is also used to reach the misalignment rejection and the scaled address return.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int unsigned QM_PEND_BASE = 32'h0000_0090;
  localparam int unsigned QM_RGN_BASE  = 32'h0000_1000;
  localparam int unsigned QM_RGN_CTRL  = 32'h0000_1004;
  localparam int unsigned QM_QUE_BASE  = 32'h0000_2000;

  typedef struct packed {
    logic pushEn;
    logic popEn;
  } qmStrobe_t;
endpackage

// File: rtl/qm_data.sv
module qm_data #(
  parameter int NUM_QUEUES = 160,
  parameter int LINK_DEPTH = 128,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int IW = $clog2(LINK_DEPTH),
  localparam int CW = $clog2(LINK_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  qm_pkg::qmStrobe_t     st,
  input  logic [QW-1:0]         pushQ,
  input  logic [IW-1:0]         pushIdx,
  input  logic [4:0]            pushHint,
  input  logic [QW-1:0]         popQ,
  output logic [IW-1:0]         headIdx,
  output logic [4:0]            headHint,
  output logic [NUM_QUEUES-1:0] nonEmpty
);
  logic [IW-1:0] headQ [NUM_QUEUES];
  logic [IW-1:0] tailQ [NUM_QUEUES];
  logic [CW-1:0] cntQ  [NUM_QUEUES];
  logic [IW-1:0] linkRam [LINK_DEPTH];
  logic [4:0]    hintRam [LINK_DEPTH];

  logic sameQ;
  assign sameQ    = st.pushEn && st.popEn && (pushQ == popQ);
  assign headIdx  = headQ[popQ];
  assign headHint = hintRam[headIdx];

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_ne
    assign nonEmpty[g] = (cntQ[g] != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        headQ[i] <= '0;
        tailQ[i] <= '0;
        cntQ[i]  <= '0;
      end
    end else begin
      if (st.popEn) begin
        headQ[popQ] <= linkRam[headQ[popQ]];
        cntQ[popQ]  <= cntQ[popQ] - CW'(1);
      end
      if (st.pushEn) begin
        if (cntQ[pushQ] == '0 || (sameQ && cntQ[pushQ] == CW'(1)))
          headQ[pushQ] <= pushIdx;
        tailQ[pushQ] <= pushIdx;
        cntQ[pushQ]  <= sameQ ? cntQ[pushQ] : cntQ[pushQ] + CW'(1);
      end
    end
  end

  // link and hint storage carry no reset; they are only read behind a count
  always_ff @(posedge clk) begin
    if (st.pushEn) begin
      if (cntQ[pushQ] != '0) linkRam[tailQ[pushQ]] <= pushIdx;
      hintRam[pushIdx] <= pushHint;
    end
  end
endmodule

// File: rtl/qm_ctrl.sv
module qm_ctrl #(
  parameter int NUM_QUEUES = 160,
  parameter int LINK_DEPTH = 128,
  parameter int ADDR_W     = 14,
  localparam int QW    = $clog2(NUM_QUEUES),
  localparam int IW    = $clog2(LINK_DEPTH),
  localparam int NPEND = (NUM_QUEUES + 31) / 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [31:0]           wrData,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [31:0]           rdData,
  output logic                  addrErr,
  output logic                  pendChg,
  output qm_pkg::qmStrobe_t     st,
  output logic [QW-1:0]         pushQ,
  output logic [IW-1:0]         pushIdx,
  output logic [4:0]            pushHint,
  output logic [QW-1:0]         popQ,
  input  logic [IW-1:0]         headIdx,
  input  logic [4:0]            headHint,
  input  logic [NUM_QUEUES-1:0] nonEmpty
);
  import qm_pkg::*;
  localparam logic [ADDR_W-1:0] QB = ADDR_W'(QM_QUE_BASE);
  localparam logic [ADDR_W-1:0] PB = ADDR_W'(QM_PEND_BASE);

  logic [31:0] rgnBase;
  logic [15:0] firstIdx;
  logic [7:0]  sizeCode;
  logic [4:0]  cntCode;
  logic [NUM_QUEUES-1:0] prevPend;

  logic [8:0]  shAmt;
  logic [5:0]  cntSh;
  assign shAmt = {1'b0, sizeCode} + 9'd5;
  assign cntSh = {1'b0, cntCode} + 6'd5;

  // push decode and address-to-index conversion
  logic [ADDR_W-5:0] wrQFull;
  logic wrIsQ, pushOk;
  logic [31:0] descAddr, offs, descNum, linkFull;
  assign wrQFull  = wrAddr[ADDR_W-1:4] - QB[ADDR_W-1:4];
  assign wrIsQ    = wrEn && (wrAddr >= QB) && (wrAddr[3:0] == 4'hC) &&
                    (32'(wrQFull) < NUM_QUEUES);
  assign descAddr = {wrData[31:5], 5'b0};
  assign offs     = descAddr - rgnBase;
  assign descNum  = offs >> shAmt;
  assign linkFull = descNum + {16'b0, firstIdx};
  assign pushOk   = (descAddr >= rgnBase) &&
                    ((offs & ~(32'hFFFF_FFFF << shAmt)) == '0) &&
                    ((descNum >> cntSh) == '0) &&
                    (linkFull < LINK_DEPTH);
  assign pushQ    = QW'(wrQFull);
  assign pushIdx  = IW'(linkFull);
  assign pushHint = wrData[4:0];

  // pop decode and index-to-address conversion
  logic [ADDR_W-5:0] rdQFull;
  logic [ADDR_W-3:0] pWord;
  logic rdIsQ, rdIsP;
  logic [31:0] popAddr;
  logic [NPEND*32-1:0] pendPad;
  assign rdQFull = rdAddr[ADDR_W-1:4] - QB[ADDR_W-1:4];
  assign rdIsQ   = rdEn && (rdAddr >= QB) && (rdAddr[3:0] == 4'hC) &&
                   (32'(rdQFull) < NUM_QUEUES);
  assign pWord   = rdAddr[ADDR_W-1:2] - PB[ADDR_W-1:2];
  assign rdIsP   = rdEn && (rdAddr >= PB) && (rdAddr[1:0] == 2'b00) &&
                   (32'(pWord) < NPEND);
  assign popQ    = QW'(rdQFull);
  assign popAddr = rgnBase + ((32'(headIdx) - {16'b0, firstIdx}) << shAmt);

  always_comb begin
    pendPad = '0;
    pendPad[NUM_QUEUES-1:0] = nonEmpty;
  end

  assign st.pushEn = wrIsQ && pushOk;
  assign st.popEn  = rdIsQ && nonEmpty[popQ];

  always_comb begin
    rdData = '0;
    if (rdIsQ) begin
      if (nonEmpty[popQ]) rdData = (popAddr & ~32'h1F) | {27'b0, headHint};
    end else if (rdIsP) begin
      rdData = pendPad[32'(pWord)*32 +: 32];
    end else if (rdEn && rdAddr == ADDR_W'(QM_RGN_BASE)) begin
      rdData = rgnBase;
    end else if (rdEn && rdAddr == ADDR_W'(QM_RGN_CTRL)) begin
      rdData = {firstIdx, sizeCode, 3'b0, cntCode};
    end
  end

  assign pendChg = |(nonEmpty ^ prevPend);

  always_ff @(posedge clk) begin
    if (rst) begin
      rgnBase  <= '0;
      firstIdx <= '0;
      sizeCode <= '0;
      cntCode  <= '0;
      addrErr  <= 1'b0;
      prevPend <= '0;
    end else begin
      addrErr  <= wrIsQ && !pushOk;
      prevPend <= nonEmpty;
      if (wrEn && wrAddr == ADDR_W'(QM_RGN_BASE)) rgnBase <= wrData;
      if (wrEn && wrAddr == ADDR_W'(QM_RGN_CTRL)) begin
        firstIdx <= wrData[31:16];
        sizeCode <= wrData[15:8];
        cntCode  <= wrData[4:0];
      end
    end
  end
endmodule

// File: rtl/qm_top.sv
module qm_top #(
  parameter int NUM_QUEUES = 160,
  parameter int LINK_DEPTH = 128,
  parameter int ADDR_W     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              addrErr,
  output logic              pendChg
);
  localparam int QW = $clog2(NUM_QUEUES);
  localparam int IW = $clog2(LINK_DEPTH);

  qm_pkg::qmStrobe_t     st;
  logic [QW-1:0]         pushQ, popQ;
  logic [IW-1:0]         pushIdx, headIdx;
  logic [4:0]            pushHint, headHint;
  logic [NUM_QUEUES-1:0] nonEmpty;

  qm_ctrl #(.NUM_QUEUES(NUM_QUEUES), .LINK_DEPTH(LINK_DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .addrErr(addrErr),
    .pendChg(pendChg), .st(st), .pushQ(pushQ), .pushIdx(pushIdx),
    .pushHint(pushHint), .popQ(popQ), .headIdx(headIdx), .headHint(headHint),
    .nonEmpty(nonEmpty)
  );

  qm_data #(.NUM_QUEUES(NUM_QUEUES), .LINK_DEPTH(LINK_DEPTH)) u_data (
    .clk(clk), .rst(rst), .st(st), .pushQ(pushQ), .pushIdx(pushIdx),
    .pushHint(pushHint), .popQ(popQ), .headIdx(headIdx), .headHint(headHint),
    .nonEmpty(nonEmpty)
  );
endmodule

// File: rtl/qm_checker.sv
module qm_checker #(
  parameter int NUM_QUEUES = 160,
  parameter int ADDR_W     = 14,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     rdAddr,
  input logic [31:0]           rdData,
  input logic                  addrErr,
  input qm_pkg::qmStrobe_t     st,
  input logic [QW-1:0]         pushQ,
  input logic [QW-1:0]         popQ,
  input logic [NUM_QUEUES-1:0] nonEmpty
);
  localparam logic [ADDR_W-1:0] QB = ADDR_W'(qm_pkg::QM_QUE_BASE);
  logic [ADDR_W-5:0] chkQ;
  logic chkIsQ;
  assign chkQ   = rdAddr[ADDR_W-1:4] - QB[ADDR_W-1:4];
  assign chkIsQ = (rdAddr >= QB) && (rdAddr[3:0] == 4'hC) && (32'(chkQ) < NUM_QUEUES);

  // R3: a read of an empty queue yields zero
  a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rdEn && chkIsQ && !nonEmpty[QW'(chkQ)]) |-> (rdData == 32'h0));

  // R6: an error flag always follows a write
  a_r6_err_follows_write: assert property (@(posedge clk) disable iff (rst)
    addrErr |-> $past(wrEn));

  // R6: a rejected push never reached the queue storage
  a_r6_err_no_push: assert property (@(posedge clk) disable iff (rst)
    addrErr |-> !$past(st.pushEn));

  for (genvar k = 0; k < NUM_QUEUES; k++) begin : g_pend
    // R4: a pending bit only rises after a push into that queue
    a_r4_pend_set: assert property (@(posedge clk) disable iff (rst)
      (nonEmpty[k] && !$past(nonEmpty[k])) |-> $past(st.pushEn && pushQ == QW'(k)));
    // R4: a pending bit only falls after a pop from that queue
    a_r4_pend_clear: assert property (@(posedge clk) disable iff (rst)
      (!nonEmpty[k] && $past(nonEmpty[k])) |-> $past(st.popEn && popQ == QW'(k)));
  end
endmodule

bind qm_top qm_checker #(.NUM_QUEUES(NUM_QUEUES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdData(rdData), .addrErr(addrErr), .st(st), .pushQ(pushQ), .popQ(popQ),
  .nonEmpty(nonEmpty)
);

// File: tb/sim_qm_top.sv
`timescale 1ns/1ps
module sim_qm_top;
  localparam int NQ = 40;
  localparam int LD = 64;
  localparam int AW = 14;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic addrErr, pendChg;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  qm_top #(.NUM_QUEUES(NQ), .LINK_DEPTH(LD), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .addrErr(addrErr),
    .pendChg(pendChg)
  );

  function automatic logic [AW-1:0] qAddr(int q);
    return AW'(32'h200C + 16 * q);
  endfunction
  function automatic logic [31:0] dsc(int n, int sz = 32);
    return BASE + 32'(n * sz);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask
  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask
  task automatic both(int q, logic [31:0] d, output logic [31:0] v);
    wrEn = 1'b1; wrAddr = qAddr(q); wrData = d;
    rdEn = 1'b1; rdAddr = qAddr(q);
    #1 v = rdData;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R8 reset pendChg", {31'b0, pendChg}, 32'h0);
    chk("R6 reset addrErr", {31'b0, addrErr}, 32'h0);
    rd(AW'(32'h90), v); chk("R4 reset pend0", v, 32'h0);
    rd(AW'(32'h1000), v); chk("R5 reset base", v, 32'h0);
  endtask

  task automatic t_region();
    logic [31:0] v;
    wr(AW'(32'h1000), BASE);
    wr(AW'(32'h1004), 32'h0020_00FF);
    rd(AW'(32'h1000), v); chk("R5 base readback", v, BASE);
    rd(AW'(32'h1004), v); chk("R5 ctrl readback", v, 32'h0020_001F);
    wr(AW'(32'h1004), 32'h0020_0000);
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    wr(qAddr(3), dsc(0) | 32'd2);
    wr(qAddr(3), dsc(5) | 32'd1);
    wr(qAddr(3), dsc(31) | 32'd3);
    rd(AW'(32'h90), v); chk("R4 pend bit3", v, 32'h8);
    rd(qAddr(3), v); chk("R1 R2 pop first", v, dsc(0) | 32'd2);
    rd(qAddr(3), v); chk("R1 R2 pop second", v, dsc(5) | 32'd1);
    rd(qAddr(3), v); chk("R1 R2 pop last idx", v, dsc(31) | 32'd3);
    rd(qAddr(3), v); chk("R3 pop empty", v, 32'h0);
    rd(AW'(32'h90), v); chk("R4 pend bit3 clear", v, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(qAddr(33), dsc(7) | 32'd2);
    chk("R8 pendChg after set", {31'b0, pendChg}, 32'h1);
    rd(AW'(32'h94), v); chk("R4 pend word1", v, 32'h2);
    chk("R8 pendChg idle", {31'b0, pendChg}, 32'h0);
    wr(AW'(32'h90), 32'hFFFF_FFFF);
    rd(AW'(32'h90), v); chk("R4 write ignored", v, 32'h0);
    rd(qAddr(33), v); chk("R1 pop q33", v, dsc(7) | 32'd2);
    chk("R8 pendChg after clear", {31'b0, pendChg}, 32'h1);
    rd(AW'(32'h94), v); chk("R4 pend word1 clear", v, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    wr(qAddr(10), 32'h7FFF_FFE2);
    chk("R6 below base err", {31'b0, addrErr}, 32'h1);
    wr(qAddr(10), dsc(32) | 32'd2);
    chk("R6 over count err", {31'b0, addrErr}, 32'h1);
    rd(AW'(32'h90), v); chk("R6 no pending", v, 32'h0);
    rd(qAddr(10), v); chk("R6 queue empty", v, 32'h0);
    wr(AW'(32'h1004), 32'h0030_0000);
    wr(qAddr(10), dsc(16));
    chk("R6 link overflow err", {31'b0, addrErr}, 32'h1);
    wr(qAddr(10), dsc(15) | 32'd4);
    chk("R6 good push no err", {31'b0, addrErr}, 32'h0);
    rd(qAddr(10), v); chk("R5 first48 pop", v, dsc(15) | 32'd4);
    wr(AW'(32'h1004), 32'h0020_0100);
    wr(qAddr(11), dsc(1));
    chk("R6 misaligned err", {31'b0, addrErr}, 32'h1);
    wr(qAddr(11), dsc(3, 64) | 32'd6);
    wr(qAddr(11), dsc(31, 64) | 32'd7);
    rd(qAddr(11), v); chk("R5 size64 pop a", v, dsc(3, 64) | 32'd6);
    rd(qAddr(11), v); chk("R5 size64 pop b", v, dsc(31, 64) | 32'd7);
    wr(AW'(32'h1004), 32'h0020_0000);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    wr(qAddr(5), dsc(1) | 32'd2);
    wr(qAddr(5), dsc(2) | 32'd2);
    both(5, dsc(3) | 32'd1, v); chk("R7 pop old head", v, dsc(1) | 32'd2);
    rd(qAddr(5), v); chk("R7 then second", v, dsc(2) | 32'd2);
    rd(qAddr(5), v); chk("R7 then pushed", v, dsc(3) | 32'd1);
    rd(qAddr(5), v); chk("R7 count kept", v, 32'h0);
    both(6, dsc(4) | 32'd2, v); chk("R7 empty pop zero", v, 32'h0);
    rd(qAddr(6), v); chk("R7 push landed", v, dsc(4) | 32'd2);
    wr(qAddr(7), dsc(8) | 32'd2);
    both(7, dsc(9) | 32'd3, v); chk("R7 single pop", v, dsc(8) | 32'd2);
    rd(qAddr(7), v); chk("R7 single new head", v, dsc(9) | 32'd3);
    rd(qAddr(7), v); chk("R7 single drained", v, 32'h0);
  endtask

  task automatic t_indep();
    logic [31:0] v;
    wr(qAddr(0), dsc(10) | 32'd2);
    wr(qAddr(39), dsc(11) | 32'd2);
    wr(qAddr(0), dsc(12) | 32'd2);
    rd(AW'(32'h94), v); chk("R4 pend q39 partial word", v, 32'h80);
    rd(AW'(32'h90), v); chk("R4 pend q0", v, 32'h1);
    rd(qAddr(39), v); chk("R1 q39 head", v, dsc(11) | 32'd2);
    rd(qAddr(0), v); chk("R1 q0 first", v, dsc(10) | 32'd2);
    rd(qAddr(0), v); chk("R1 q0 second", v, dsc(12) | 32'd2);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_region();
    t_fifo();
    t_pending();
    t_errors();
    t_simul();
    t_indep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule